// File: doc/BRIEF.md
# Lock permission unit

This block decides, for each operation that a flash controller wants to start, whether the operation may proceed. It keeps one lock flag for each 64-Kbyte array block and one master lock flag. The per-block flags guard erasing and programming their block. The master flag guards any change to the per-block flags. An override input, which is asserted when the reset pin is held at its elevated voltage, bypasses both levels. The flag registers stand in for non-volatile cells.

The controller presents one request per cycle. A request carries an operation code, a block index and the override flag. One clock later the unit answers with exactly one of three outcomes. It grants the request, refuses it with an array error (erase or program to a locked block), or refuses it with a lock error (a lock-configuration request that is not permitted). A granted lock-configuration request is held as pending. It changes the flags only when the controller later signals that the operation has finished. A deep power-down input silences the unit and drops any pending update, and the flags survive it. Only the synchronous power-on reset or explicit commands change the flags.

Top module: `lockperm_unit`

## Requirements
- R1: The block count NUM_BLOCKS is a parameter taking 8, 16 or 32. The block index port is $clog2(NUM_BLOCKS) bits wide, and the highest index behaves like any other.
- R2: An erase (op 0) or program (op 1) request to a block whose lock flag is set, with the override low, is refused. The response has rsp_err_array high and rsp_grant low.
- R3: An erase (op 0) or program (op 1) request is granted when the target block is unlocked, or when the override is high, whatever the lock flag holds.
- R4: A set-block-lock (op 2) or clear-all-block-locks (op 4) request is refused with rsp_err_lock high while the master flag is set and the override is low. Otherwise it is granted.
- R5: A set-master-lock (op 3) request is granted only with the override high. Without the override it is refused with rsp_err_lock high.
- R6: A committed clear-all-block-locks operation clears every block lock flag in the same cycle. It leaves the master flag set.
- R7: The response appears in the cycle after the request and lasts one cycle. For op codes 0 to 4, exactly one of rsp_grant, rsp_err_array and rsp_err_lock is high. Op codes 5 to 7 produce rsp_valid with all three low.
- R8: Lock flags change only when op_done is pulsed while a granted lock-configuration update is pending. op_done with nothing pending has no effect. Granted erase and program requests never change a flag.
- R9: A new request that arrives before op_done cancels the pending update.
- R10: While pwrdn is high, requests get no response and any pending update is discarded. All lock flags and the master flag are retained.
- R11: A synchronous reset (rst high) clears every block lock flag, the master flag, the pending update and the response.
- R12: A committed set-block-lock operation sets the flag of the addressed block only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pwrdn | input | 1 | Deep power-down: silences responses, drops pending update |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (0 erase, 1 program, 2 set block lock, 3 set master lock, 4 clear all block locks) |
| req_blk | input | $clog2(NUM_BLOCKS) | Target block index |
| req_hv | input | 1 | High-voltage override on the reset pin |
| op_done | input | 1 | Controller pulse: the granted operation finished |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Request granted |
| rsp_err_array | output | 1 | Erase or program refused by a block lock |
| rsp_err_lock | output | 1 | Lock configuration refused |

## Verification
The bench builds the unit with NUM_BLOCKS set to 8. With that setting it can probe every block's flag after a clear-all in a few cycles, and it can reach the highest index 7 with a 3-bit index. It observes the flags only through responses. Erase requests without the override reveal block flags, and set-block-lock requests without the override reveal the master flag. Each master probe is followed by a harmless request, so the probe's own pending update is cancelled. The directed scenarios cover the interplay of pending updates, cancellation, power-down and the two lock levels.

// File: rtl/lockperm_pkg.sv
package lockperm_pkg;

    typedef enum logic [2:0] {
        OP_ERASE  = 3'd0,
        OP_PROG   = 3'd1,
        OP_SETBLK = 3'd2,
        OP_SETMST = 3'd3,
        OP_CLRALL = 3'd4
    } lp_op_e;

    typedef enum logic [1:0] {
        UPD_NONE   = 2'd0,
        UPD_SETBLK = 2'd1,
        UPD_SETMST = 2'd2,
        UPD_CLRALL = 2'd3
    } lp_upd_e;

    typedef struct packed {
        logic valid;
        logic grant;
        logic err_array;
        logic err_lock;
    } lp_rsp_t;

    // Permission verdict for one request against the current flags.
    function automatic lp_rsp_t lp_judge(input logic [2:0] op,
                                         input logic       blk_locked,
                                         input logic       master_set,
                                         input logic       hv);
        lp_rsp_t r;
        r       = '0;
        r.valid = 1'b1;
        case (op)
            OP_ERASE, OP_PROG: begin
                if (blk_locked && !hv) r.err_array = 1'b1;
                else                   r.grant     = 1'b1;
            end
            OP_SETBLK, OP_CLRALL: begin
                if (master_set && !hv) r.err_lock = 1'b1;
                else                   r.grant    = 1'b1;
            end
            OP_SETMST: begin
                if (hv) r.grant    = 1'b1;
                else    r.err_lock = 1'b1;
            end
            default: ;
        endcase
        return r;
    endfunction

    // Which flag update a granted request would later commit.
    function automatic lp_upd_e lp_upd_of(input logic [2:0] op);
        case (op)
            OP_SETBLK: return UPD_SETBLK;
            OP_SETMST: return UPD_SETMST;
            OP_CLRALL: return UPD_CLRALL;
            default:   return UPD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/lp_lock_store.sv
module lp_lock_store
    import lockperm_pkg::*;
#(
    parameter int NUM_BLOCKS = 32,
    parameter int IDXW       = $clog2(NUM_BLOCKS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  commit,
    input  lp_upd_e               commit_kind,
    input  logic [IDXW-1:0]       commit_blk,
    output logic [NUM_BLOCKS-1:0] blk_lock,
    output logic                  master_lock
);

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                blk_lock[i] <= 1'b0;
            else if (commit && commit_kind == UPD_CLRALL)
                blk_lock[i] <= 1'b0;
            else if (commit && commit_kind == UPD_SETBLK && commit_blk == IDXW'(i))
                blk_lock[i] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            master_lock <= 1'b0;
        else if (commit && commit_kind == UPD_SETMST)
            master_lock <= 1'b1;
    end

    // R8: flags hold still unless an update is committed
    a_r8_hold_without_commit: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable({master_lock, blk_lock}));

    // R6: clear-all empties every block flag, master untouched
    a_r6_clear_all: assert property (@(posedge clk) disable iff (rst)
        (commit && commit_kind == UPD_CLRALL) |=> (blk_lock == '0 && $stable(master_lock)));

    // R12: set-block-lock raises at most one flag
    a_r12_single_block: assert property (@(posedge clk) disable iff (rst)
        (commit && commit_kind == UPD_SETBLK) |=>
            ($countones(blk_lock & ~$past(blk_lock)) <= 1));

endmodule

// File: rtl/lp_perm_eval.sv
module lp_perm_eval
    import lockperm_pkg::*;
#(
    parameter int NUM_BLOCKS = 32,
    parameter int IDXW       = $clog2(NUM_BLOCKS)
) (
    input  logic [2:0]            op,
    input  logic [IDXW-1:0]       blk,
    input  logic                  hv,
    input  logic [NUM_BLOCKS-1:0] blk_lock,
    input  logic                  master_lock,
    output lp_rsp_t               verdict,
    output lp_upd_e               upd_kind
);

    logic target_locked;

    always_comb begin
        target_locked = blk_lock[blk];
        verdict       = lp_judge(op, target_locked, master_lock, hv);
        upd_kind      = lp_upd_of(op);
    end

    // R7: a verdict never both grants and refuses
    always_comb begin
        a_r7_verdict_exclusive: assert ($countones({verdict.grant, verdict.err_array,
                                                    verdict.err_lock}) <= 1);
    end

endmodule

// File: rtl/lp_rsp_stage.sv
module lp_rsp_stage
    import lockperm_pkg::*;
#(
    parameter int IDXW = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pwrdn,
    input  logic            req_valid,
    input  logic [IDXW-1:0] req_blk,
    input  lp_rsp_t         verdict,
    input  lp_upd_e         upd_kind,
    input  logic            op_done,
    output lp_rsp_t         rsp,
    output logic            commit,
    output lp_upd_e         commit_kind,
    output logic [IDXW-1:0] commit_blk
);

    lp_upd_e         pend_kind;
    logic [IDXW-1:0] pend_blk;

    always_ff @(posedge clk) begin
        if (rst || pwrdn) begin
            rsp       <= '0;
            pend_kind <= UPD_NONE;
            pend_blk  <= '0;
        end else begin
            rsp.valid     <= req_valid & verdict.valid;
            rsp.grant     <= req_valid & verdict.grant;
            rsp.err_array <= req_valid & verdict.err_array;
            rsp.err_lock  <= req_valid & verdict.err_lock;
            if (req_valid) begin
                pend_kind <= verdict.grant ? upd_kind : UPD_NONE;
                pend_blk  <= req_blk;
            end else if (op_done) begin
                pend_kind <= UPD_NONE;
            end
        end
    end

    always_comb begin
        commit      = op_done && !rst && !pwrdn && (pend_kind != UPD_NONE);
        commit_kind = pend_kind;
        commit_blk  = pend_blk;
    end

    // R10: no response follows a power-down cycle
    a_r10_pwrdn_silent: assert property (@(posedge clk) disable iff (rst)
        pwrdn |=> !rsp.valid);

    // R7: response lasts a single cycle when no new request follows
    a_r7_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (rsp.valid && !req_valid) |=> !rsp.valid);

    // R7: outcomes only ride on a valid response
    a_r7_outcome_needs_valid: assert property (@(posedge clk) disable iff (rst)
        (rsp.grant || rsp.err_array || rsp.err_lock) |-> rsp.valid);

endmodule

// File: rtl/lockperm_unit.sv
module lockperm_unit
    import lockperm_pkg::*;
#(
    parameter int  NUM_BLOCKS = 32,
    localparam int IDXW       = $clog2(NUM_BLOCKS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pwrdn,
    input  logic            req_valid,
    input  logic [2:0]      req_op,
    input  logic [IDXW-1:0] req_blk,
    input  logic            req_hv,
    input  logic            op_done,
    output logic            rsp_valid,
    output logic            rsp_grant,
    output logic            rsp_err_array,
    output logic            rsp_err_lock
);

    logic [NUM_BLOCKS-1:0] blk_lock;
    logic                  master_lock;
    lp_rsp_t               verdict;
    lp_upd_e               upd_kind;
    lp_rsp_t               rsp;
    logic                  commit;
    lp_upd_e               commit_kind;
    logic [IDXW-1:0]       commit_blk;

    lp_lock_store #(.NUM_BLOCKS(NUM_BLOCKS), .IDXW(IDXW)) u_store (
        .clk        (clk),
        .rst        (rst),
        .commit     (commit),
        .commit_kind(commit_kind),
        .commit_blk (commit_blk),
        .blk_lock   (blk_lock),
        .master_lock(master_lock)
    );

    lp_perm_eval #(.NUM_BLOCKS(NUM_BLOCKS), .IDXW(IDXW)) u_eval (
        .op         (req_op),
        .blk        (req_blk),
        .hv         (req_hv),
        .blk_lock   (blk_lock),
        .master_lock(master_lock),
        .verdict    (verdict),
        .upd_kind   (upd_kind)
    );

    lp_rsp_stage #(.IDXW(IDXW)) u_rsp (
        .clk        (clk),
        .rst        (rst),
        .pwrdn      (pwrdn),
        .req_valid  (req_valid),
        .req_blk    (req_blk),
        .verdict    (verdict),
        .upd_kind   (upd_kind),
        .op_done    (op_done),
        .rsp        (rsp),
        .commit     (commit),
        .commit_kind(commit_kind),
        .commit_blk (commit_blk)
    );

    assign rsp_valid     = rsp.valid;
    assign rsp_grant     = rsp.grant;
    assign rsp_err_array = rsp.err_array;
    assign rsp_err_lock  = rsp.err_lock;

    // R2: locked block, no override -> array error next cycle
    a_r2_locked_refused: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !pwrdn && (req_op == 3'd0 || req_op == 3'd1) &&
         blk_lock[req_blk] && !req_hv) |=> (rsp_valid && rsp_err_array && !rsp_grant));

    // R3: override always admits erase and program
    a_r3_override_grants: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !pwrdn && (req_op == 3'd0 || req_op == 3'd1) && req_hv)
            |=> (rsp_valid && rsp_grant));

    // R5: master lock needs the override
    a_r5_master_needs_hv: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !pwrdn && req_op == 3'd3 && !req_hv)
            |=> (rsp_err_lock && !rsp_grant));

    // R4: master set gates lock configuration
    a_r4_master_gates: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !pwrdn && (req_op == 3'd2 || req_op == 3'd4) &&
         master_lock && !req_hv) |=> (rsp_err_lock && !rsp_grant));

    // R10: flags survive power-down
    a_r10_flags_kept: assert property (@(posedge clk) disable iff (rst)
        pwrdn |=> $stable({master_lock, blk_lock}));

endmodule

// File: tb/lockperm_unit_tb.sv
module lockperm_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 8;
    localparam int IW         = $clog2(NB);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwrdn = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = '0;
    logic [IW-1:0] req_blk = '0;
    logic          req_hv = 1'b0;
    logic          op_done = 1'b0;
    logic          rsp_valid, rsp_grant, rsp_err_array, rsp_err_lock;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lockperm_unit #(.NUM_BLOCKS(NB)) u_dut (
        .clk(clk), .rst(rst), .pwrdn(pwrdn),
        .req_valid(req_valid), .req_op(req_op), .req_blk(req_blk), .req_hv(req_hv),
        .op_done(op_done),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .rsp_err_array(rsp_err_array), .rsp_err_lock(rsp_err_lock)
    );

    task automatic check4(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: {valid,grant,err_array,err_lock} actual %b expected %b",
                     tag, act, exp);
        end
    endtask

    // Present one request for one cycle; on return the response is visible.
    task automatic issue(input logic [2:0] op, input int blk, input logic hv);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_blk   = IW'(blk);
        req_hv    = hv;
        @(negedge clk);
        req_valid = 1'b0;
        req_hv    = 1'b0;
    endtask

    task automatic expect_rsp(input string tag, input logic g, input logic ea, input logic el);
        check4(tag, {rsp_valid, rsp_grant, rsp_err_array, rsp_err_lock}, {1'b1, g, ea, el});
    endtask

    task automatic pulse_done();
        @(negedge clk);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    task automatic probe_block(input string tag, input int blk, input logic locked);
        issue(3'd0, blk, 1'b0);
        expect_rsp(tag, !locked, locked, 1'b0);
    endtask

    // Set-block-lock without override reveals the master flag; a following
    // harmless request cancels the pending update the probe may create.
    task automatic probe_master(input string tag, input logic set);
        issue(3'd2, 0, 1'b0);
        expect_rsp(tag, !set, 1'b0, set);
        issue(3'd1, 0, 1'b1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check4("R11 response idle in reset",
               {rsp_valid, rsp_grant, rsp_err_array, rsp_err_lock}, 4'b0000);
        rst = 1'b0;
        for (int b = 0; b < NB; b++) probe_block("R11 block clear after reset", b, 1'b0);
        probe_master("R11 master clear after reset", 1'b0);
    endtask

    task automatic t_block_lock();
        issue(3'd2, 3, 1'b0);
        expect_rsp("R4 set block lock granted, master clear", 1'b1, 1'b0, 1'b0);
        pulse_done();
        probe_block("R2 erase to locked block 3", 3, 1'b1);
        probe_block("R12 neighbour block 2 unlocked", 2, 1'b0);
        probe_block("R12 neighbour block 4 unlocked", 4, 1'b0);
        issue(3'd1, 3, 1'b0);
        expect_rsp("R2 program to locked block 3", 1'b0, 1'b1, 1'b0);
        issue(3'd1, 3, 1'b1);
        expect_rsp("R3 program locked block with override", 1'b1, 1'b0, 1'b0);
        issue(3'd0, 3, 1'b1);
        expect_rsp("R3 erase locked block with override", 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check4("R7 response lasts one cycle",
               {rsp_valid, rsp_grant, rsp_err_array, rsp_err_lock}, 4'b0000);
        probe_block("R8 granted erase left block 3 locked", 3, 1'b1);
    endtask

    task automatic t_cancel_and_idle_done();
        issue(3'd2, 5, 1'b0);
        expect_rsp("R9 set block 5 granted", 1'b1, 1'b0, 1'b0);
        probe_block("R8 block 5 not locked before done", 5, 1'b0);
        pulse_done();
        probe_block("R9 cancelled update stays uncommitted", 5, 1'b0);
        pulse_done();
        probe_block("R8 idle done leaves block 3 locked", 3, 1'b1);
        probe_block("R8 idle done leaves block 5 clear", 5, 1'b0);
    endtask

    task automatic t_master();
        issue(3'd3, 0, 1'b0);
        expect_rsp("R5 master lock refused without override", 1'b0, 1'b0, 1'b1);
        pulse_done();
        probe_master("R5 refused master not set", 1'b0);
        issue(3'd3, 0, 1'b1);
        expect_rsp("R5 master lock granted with override", 1'b1, 1'b0, 1'b0);
        pulse_done();
        probe_master("R4 master now gates set block lock", 1'b1);
        issue(3'd4, 0, 1'b0);
        expect_rsp("R4 clear all refused under master", 1'b0, 1'b0, 1'b1);
        issue(3'd2, 6, 1'b1);
        expect_rsp("R4 set block 6 with override", 1'b1, 1'b0, 1'b0);
        pulse_done();
        probe_block("R4 block 6 locked via override", 6, 1'b1);
    endtask

    task automatic t_pwrdn();
        @(negedge clk);
        pwrdn = 1'b1;
        issue(3'd0, 0, 1'b0);
        check4("R10 no response in power-down",
               {rsp_valid, rsp_grant, rsp_err_array, rsp_err_lock}, 4'b0000);
        @(negedge clk);
        pwrdn = 1'b0;
        issue(3'd2, 1, 1'b1);
        expect_rsp("R10 set block 1 granted", 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        pwrdn = 1'b1;
        @(negedge clk);
        pwrdn = 1'b0;
        pulse_done();
        probe_block("R10 pending update dropped by power-down", 1, 1'b0);
        probe_block("R10 block 3 kept through power-down", 3, 1'b1);
        probe_block("R10 block 6 kept through power-down", 6, 1'b1);
        probe_master("R10 master kept through power-down", 1'b1);
    endtask

    task automatic t_clear_all();
        issue(3'd4, 0, 1'b1);
        expect_rsp("R6 clear all granted with override", 1'b1, 1'b0, 1'b0);
        pulse_done();
        for (int b = 0; b < NB; b++) probe_block("R6 block clear after clear-all", b, 1'b0);
        probe_master("R6 master survives clear-all", 1'b1);
    endtask

    task automatic t_misc();
        issue(3'd6, 2, 1'b1);
        expect_rsp("R7 undefined code 6 gives no outcome", 1'b0, 1'b0, 1'b0);
        issue(3'd5, 0, 1'b0);
        expect_rsp("R7 undefined code 5 gives no outcome", 1'b0, 1'b0, 1'b0);
        issue(3'd2, NB - 1, 1'b1);
        expect_rsp("R1 set highest block granted", 1'b1, 1'b0, 1'b0);
        pulse_done();
        probe_block("R1 highest block locked", NB - 1, 1'b1);
        probe_block("R1 block 0 unaffected", 0, 1'b0);
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        probe_block("R11 reset clears highest block", NB - 1, 1'b0);
        probe_master("R11 reset clears master", 1'b0);
    endtask

    initial begin
        t_reset();
        t_block_lock();
        t_cancel_and_idle_done();
        t_master();
        t_pwrdn();
        t_clear_all();
        t_misc();
        t_reset_again();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule